// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block turns a reference clock into a card clock running at the reference rate divided by 1, 2, 4 or 8. A two-bit select picks the ratio, and an enable input gates the card clock. When the card clock is disabled, it rests low. The card clock may run at most 20 MHz, and the reference may run up to 26 MHz. System software therefore chooses a ratio that keeps the card side within its limit.

The select and enable inputs may change at any moment, even while the card clock is running. Both inputs pass through a two-stage synchronizer. A free-running three-bit counter then holds the synchronized setting until the counter wraps. At the wrap, every divided clock is at the start of its low phase, and the previous output has just finished a complete high phase. Because of this, no truncated pulse can appear when the ratio changes.

For ratios 2, 4 and 8, the output is a registered counter bit, which gives an exact 50 % duty cycle. For ratio 1, the reference clock is passed through an AND gate. The gate enable is updated on the falling edge of the reference, so the output keeps the reference duty cycle.

Top module: `clkdiv_sel`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low. After reset the output stays low until an enable is adopted.
- R2: The `ratio_sel` encoding is 0 for divide by 1, 1 for divide by 2, 2 for divide by 4 and 3 for divide by 8. In steady state, each low phase of `clk_out` lasts N/2 reference cycles, or half a reference cycle for divide by 1.
- R3: In steady state, each high phase lasts N/2 reference cycles, or half a reference cycle for divide by 1. This gives 50 % duty for every ratio.
- R4: `ratio_sel` and `enable` are synchronized through two flip-flops. A new setting is adopted only at the wrap of the three-bit counter, which is the point where every divided clock starts its low phase.
- R5: No runt pulses. Under any pattern of select or enable changes, every high pulse of `clk_out` lasts exactly 0.5, 1, 2 or 4 reference cycles.
- R6: Once a low `enable` has been adopted, `clk_out` stays low. After `enable` is adopted high, the output begins with a low phase, and its first high pulse is complete.
- R7: A setting held stable for 12 reference cycles is in force after those 12 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Card clock enable (asynchronous) |
| ratio_sel | input | 2 | Divide ratio select (asynchronous) |
| clk_out | output | 1 | Divided, gated card clock |

## Verification
The hard case is a ratio change and an enable change arriving at the same counter wrap. A closely related case is a new selection reaching the synchronizer output while the old divided clock is still in its last high phase. The bench provokes both by re-randomizing the select and enable inputs every one to five cycles, so they often change together and close to a wrap. It samples the output twice per reference cycle and judges every high pulse by its width, which must be one of the legal half-periods. Between these bursts, it holds each setting long enough to check that the exact period, duty cycle and quiet level are reached.

// File: rtl/clkdiv_sel.sv
module clkdiv_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] ratio_sel,
  output logic       clk_out
);
  localparam int CW = 3;
  localparam int PW = 3;
  localparam logic [CW-1:0] WRAP = '1;

  logic [SYNC_STAGES*PW-1:0] pipe;
  logic [1:0]    sel_s, cur, cur_nx;
  logic          en_s, en_act, en_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          wrap, q_out, q_nx, run1;

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[(SYNC_STAGES-1)*PW-1:0], enable, ratio_sel};

  assign {en_s, sel_s} = pipe[SYNC_STAGES*PW-1 -: PW];

  assign wrap   = (cnt == WRAP);
  assign cnt_nx = cnt + 1'b1;
  assign cur_nx = wrap ? sel_s : cur;
  assign en_nx  = wrap ? en_s  : en_act;

  always_comb begin
    case (cur_nx)
      2'd1:    q_nx = cnt_nx[0];
      2'd2:    q_nx = cnt_nx[1];
      2'd3:    q_nx = cnt_nx[2];
      default: q_nx = 1'b0;
    endcase
    q_nx = q_nx & en_nx;
  end

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      cur    <= 2'd0;
      en_act <= 1'b0;
      q_out  <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
      cur    <= cur_nx;
      en_act <= en_nx;
      q_out  <= q_nx;
    end

  logic pass_now, pass_next;
  assign pass_now  = en_act && (cur == 2'd0);
  assign pass_next = en_s && (sel_s == 2'd0);

  always_ff @(negedge clk_in or negedge rst_n)
    if (!rst_n) run1 <= 1'b0;
    else        run1 <= wrap ? (pass_now && pass_next) : pass_now;

  assign clk_out = q_out | (clk_in & run1);
endmodule

module clkdiv_sel_chk (
  input logic       clk_in,
  input logic       rst_n,
  input logic       clk_out,
  input logic       q_out,
  input logic       run1,
  input logic [2:0] cnt,
  input logic [1:0] cur,
  input logic       en_act,
  input logic [1:0] sel_s,
  input logic       en_s
);
  a_r1_low_in_reset: assert property (@(posedge clk_in)
    !rst_n |-> !clk_out);

  a_r4_adopt_only_at_wrap: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cnt != 3'd7) |=> ($stable(cur) && $stable(en_act)));

  a_r4_new_setting_starts_low: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cnt == 3'd7 && (sel_s != cur || en_s != en_act)) |=> !q_out);

  a_r5_paths_exclusive: assert property (@(posedge clk_in) disable iff (!rst_n)
    !(q_out && run1));

  a_r6_quiet_when_off: assert property (@(posedge clk_in) disable iff (!rst_n)
    !en_act |-> (!q_out && !run1));

  a_r3_div2_toggles: assert property (@(posedge clk_in) disable iff (!rst_n)
    (en_act && cur == 2'd1 && cnt != 3'd7) |=> (q_out != $past(q_out)));
endmodule

bind clkdiv_sel clkdiv_sel_chk u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .clk_out(clk_out), .q_out(q_out), .run1(run1),
  .cnt(cnt), .cur(cur), .en_act(en_act), .sel_s(sel_s), .en_s(en_s)
);

// File: tb/tb_clkdiv_sel.sv
module tb_clkdiv_sel;
  localparam int PERIOD = 20;

  logic       clk_in = 1'b0;
  logic       rst_n  = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] ratio_sel = 2'd0;
  logic       clk_out;

  int  checks = 0, failures = 0;
  bit  steady = 0, exp_en = 0, done = 0;
  int  exp_n = 1;
  bit  prev = 0, run_flag = 0;
  int  run_len = 0;

  clkdiv_sel dut (.clk_in(clk_in), .rst_n(rst_n), .enable(enable),
                  .ratio_sel(ratio_sel), .clk_out(clk_out));

  always #(PERIOD/2) clk_in = ~clk_in;

  function automatic int half_len(input logic [1:0] s);
    return 1 << s;
  endfunction

  function automatic bit legal_high(input int len);
    return (len == 1) || (len == 2) || (len == 4) || (len == 8);
  endfunction

  task automatic end_run(input bit lvl, input int len, input bit flag);
    if (lvl) begin
      checks++;
      if (!legal_high(len)) begin
        failures++;
        $display("FAIL R5 high pulse half-cycles actual=%0d expected one of 1,2,4,8", len);
      end
    end
    if (flag) begin
      checks++;
      if (len != exp_n) begin
        failures++;
        $display("FAIL %s %s phase half-cycles actual=%0d expected=%0d",
                 lvl ? "R3" : "R2", lvl ? "high" : "low", len, exp_n);
      end
    end
  endtask

  task automatic take(input bit s);
    if (!rst_n) begin
      checks++;
      if (s) begin
        failures++;
        $display("FAIL R1 clk_out in reset actual=%0b expected=0", s);
      end
      run_len = 0;
      return;
    end
    if (steady && !exp_en) begin
      checks++;
      if (s) begin
        failures++;
        $display("FAIL R6 clk_out while disabled actual=%0b expected=0", s);
      end
    end
    if (run_len != 0 && s == prev) run_len++;
    else begin
      if (run_len != 0) end_run(prev, run_len, run_flag);
      prev = s;
      run_len = 1;
      run_flag = steady && exp_en;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_in); #(PERIOD/4); take(clk_out);
      @(negedge clk_in); #(PERIOD/4); take(clk_out);
    end
  end

  // R4 R7: a held setting must be in force after 12 cycles
  task automatic apply(input logic [1:0] s, input bit e, input int hold);
    steady = 0;
    @(posedge clk_in); #1;
    ratio_sel = s;
    enable = e;
    repeat (12) @(posedge clk_in);
    exp_n = half_len(s);
    exp_en = e;
    steady = 1;
    repeat (hold) @(posedge clk_in);
    steady = 0;
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    repeat (5) @(posedge clk_in);
    #1 rst_n = 1'b1;
    // R1: output remains low until an enable is adopted
    steady = 1; exp_en = 0;
    repeat (10) @(posedge clk_in);
    steady = 0;

    // R2 R3: each ratio in turn, R6 enable/disable
    apply(2'd3, 1'b1, 40);
    apply(2'd0, 1'b1, 16);
    apply(2'd1, 1'b1, 20);
    apply(2'd2, 1'b1, 24);
    apply(2'd3, 1'b0, 30);
    apply(2'd0, 1'b1, 16);
    apply(2'd2, 1'b0, 20);
    apply(2'd1, 1'b1, 20);

    // R5: rapid changes, select and enable together near wraps
    for (int i = 0; i < 60; i++) begin
      @(posedge clk_in); #1;
      ratio_sel = 2'($urandom_range(0, 3));
      enable = ($urandom_range(0, 4) != 0);
      repeat ($urandom_range(0, 4)) @(posedge clk_in);
    end

    // R2 R3 R6 R7: random settings held to steady state
    for (int i = 0; i < 30; i++)
      apply(2'($urandom_range(0, 3)), $urandom_range(0, 5) != 0, $urandom_range(16, 40));

    // R1: reset again mid-run
    @(posedge clk_in); #1 rst_n = 1'b0;
    repeat (4) @(posedge clk_in);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk_in);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule